// File: doc/BRIEF.md
# Memory and I/O Request Header Builder

This block turns one outbound request from the internal bus into the header of a PCI Express request TLP. The request arrives with an address that has already been translated, a read/write flag, a memory or I/O space flag, a dword length, a tag and a requester ID. The block presents the header one 32-bit dword at a time on a valid/ready stream, with a last flag on the closing dword.

The header size follows from the translated address. A memory request with any address bit at or above bit 32 set gets a 4-dword header with a 64-bit address. Every other memory request gets a 3-dword header with a 32-bit address. I/O requests always use the 3-dword form. They are legal only when the mode input selects root complex, the address lies below 4 GiB and the length is one dword. An illegal request is taken from the input and dropped, and a one-cycle error pulse follows it. The request port stays closed until the last dword of the current header has been taken.

Top module: `tlp_hdr_builder`

## Requirements
- R1: After reset, hdr_valid and err_pulse are low and req_ready is high.
- R2: A memory request whose address has any bit at or above bit 32 set produces exactly 4 dwords, with dword 0 bit 29 = 1. Every other legal request produces exactly 3 dwords, with dword 0 bit 29 = 0.
- R3: Dword 0 is laid out as follows. Bit 31 = 0. Bit 30 = 1 for a write and 0 for a read. Bits [28:24] = 5'b00000 for memory and 5'b00010 for I/O. Bits [23:10] = 0. Bits [9:0] = the length.
- R4: Dword 1 is laid out as follows. Bits [31:16] = requester ID. Bits [15:8] = tag. Bits [7:4] = 4'h0 when the length is 1 and 4'hF otherwise. Bits [3:0] = 4'hF.
- R5: In a 3-dword header, dword 2 = address[31:0] with bits [1:0] cleared. In a 4-dword header, dword 2 = the address bits above bit 31, zero-extended, and dword 3 = address[31:0] with bits [1:0] cleared.
- R6: An I/O request taken while rc_mode = 0 produces no header. err_pulse is high in the cycle after acceptance and low in the cycle after that, unless another illegal request has been taken.
- R7: In rc_mode = 1, an I/O request with an address at or above 4 GiB, or with a length other than 1, is dropped with the same error pulse as in R6 and produces no header.
- R8: One dword is taken per beat with hdr_valid and hdr_ready both high. hdr_last is high only on the final dword. While hdr_valid is high and hdr_ready is low, hdr_data and hdr_last hold.
- R9: req_ready is low from the acceptance of a legal request until its last dword is taken. A request presented in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rc_mode | input | 1 | 1 = root complex, I/O allowed; 0 = endpoint |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken |
| req_addr | input | ADDR_W (36) | Translated address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_len | input | LEN_W (10) | Length in dwords (0 means 1024) |
| req_tag | input | TAG_W (8) | Transaction tag |
| req_rid | input | RID_W (16) | Requester ID |
| hdr_valid | output | 1 | Header dword present |
| hdr_ready | input | 1 | Sink takes the dword |
| hdr_data | output | 32 | Header dword |
| hdr_last | output | 1 | Final dword of the header |
| err_pulse | output | 1 | One-cycle pulse for a dropped illegal request |

## Verification
The bench uses the default ADDR_W = 36. This leaves 4 address bits above bit 31, so all 16 values of that field can be swept. The sweep crosses those 16 values with both directions, both spaces, both modes, and a length of either 1 or some other value. It therefore reaches every header size, every I/O rejection cause and both last-byte-enable values. Stalls on the output side and requests presented while a header is being sent are interleaved through the sweep. Fixed requests at 0x0_FFFF_FFFF and 0x1_0000_0000 check the 4 GiB boundary directly.

// File: rtl/tlp_hdr_pkg.sv
package tlp_hdr_pkg;

   localparam int DW_W    = 32;
   localparam int HDR_MAX = 4;
   localparam int IDX_W   = $clog2(HDR_MAX);

   typedef logic [DW_W-1:0] dword_t;
   typedef logic [HDR_MAX-1:0][DW_W-1:0] hdr_t;

   localparam logic [4:0] TYPE_MEM = 5'b00000;
   localparam logic [4:0] TYPE_IO  = 5'b00010;

   typedef struct packed {
      logic       write;
      logic       addr64;
      logic [4:0] ttype;
   } hdr_ctl_t;

   function automatic dword_t build_dw0(hdr_ctl_t c, logic [9:0] len);
      return {1'b0, c.write, c.addr64, c.ttype, 14'd0, len};
   endfunction

   function automatic dword_t build_dw1(logic [15:0] rid, logic [7:0] tag, logic [9:0] len);
      logic [3:0] lbe;
      lbe = (len == 10'd1) ? 4'h0 : 4'hF;
      return {rid, tag, lbe, 4'hF};
   endfunction

endpackage

// File: rtl/tlp_req_classify.sv
module tlp_req_classify
   import tlp_hdr_pkg::*;
#(
   parameter int ADDR_W = 36,
   parameter int LEN_W  = 10
)(
   input  logic [ADDR_W-33:0] addr_hi,
   input  logic               write,
   input  logic               io,
   input  logic [LEN_W-1:0]   len,
   input  logic               rc_mode,
   output hdr_ctl_t           ctl,
   output logic               legal
);
   logic above4g;
   logic len_one;
   logic io_ok;

   assign above4g = |addr_hi;
   assign len_one = (len == LEN_W'(1));
   assign io_ok   = rc_mode && !above4g && len_one;

   always_comb begin
      ctl.write  = write;
      ctl.addr64 = !io && above4g;
      ctl.ttype  = io ? TYPE_IO : TYPE_MEM;
      legal      = io ? io_ok : 1'b1;
   end
endmodule

// File: rtl/tlp_hdr_format.sv
module tlp_hdr_format
   import tlp_hdr_pkg::*;
#(
   parameter int ADDR_W = 36,
   parameter int LEN_W  = 10,
   parameter int TAG_W  = 8,
   parameter int RID_W  = 16
)(
   input  hdr_ctl_t           ctl,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [LEN_W-1:0]   len,
   input  logic [TAG_W-1:0]   tag,
   input  logic [RID_W-1:0]   rid,
   output hdr_t               hdr,
   output logic [IDX_W-1:0]   last_idx
);
   dword_t     upper;
   dword_t     lower;
   logic [9:0] len10;

   generate
      if (ADDR_W == 64) begin : g_full_upper
         assign upper = addr[63:32];
      end else begin : g_pad_upper
         assign upper = 32'(addr[ADDR_W-1:32]);
      end
   endgenerate

   assign lower = addr[31:0] & ~32'h3;
   assign len10 = 10'(len);

   always_comb begin
      hdr[0]   = build_dw0(ctl, len10);
      hdr[1]   = build_dw1(16'(rid), 8'(tag), len10);
      hdr[2]   = ctl.addr64 ? upper : lower;
      hdr[3]   = ctl.addr64 ? lower : '0;
      last_idx = ctl.addr64 ? IDX_W'(3) : IDX_W'(2);
   end
endmodule

// File: rtl/tlp_hdr_sequencer.sv
module tlp_hdr_sequencer
   import tlp_hdr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  hdr_t             hdr_in,
   input  logic [IDX_W-1:0] last_in,
   output logic             busy,
   input  logic             out_ready,
   output dword_t           out_data,
   output logic             out_last
);
   hdr_t             hdr_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q  <= '0;
         last_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         hdr_q  <= hdr_in;
         last_q <= last_in;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && out_ready) begin
         if (idx_q == last_q) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign out_data = hdr_q[idx_q];
   assign out_last = busy_q && (idx_q == last_q);
endmodule

// File: rtl/tlp_hdr_builder.sv
module tlp_hdr_builder
   import tlp_hdr_pkg::*;
#(
   parameter int ADDR_W = 36,
   parameter int LEN_W  = 10,
   parameter int TAG_W  = 8,
   parameter int RID_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rc_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [RID_W-1:0]  req_rid,
   output logic              hdr_valid,
   input  logic              hdr_ready,
   output logic [31:0]       hdr_data,
   output logic              hdr_last,
   output logic              err_pulse
);
   generate
      if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ADDR_W must lie in 33..64");
      end
      if (LEN_W < 1 || LEN_W > 10) begin : g_bad_len_w
         $error("LEN_W must lie in 1..10");
      end
      if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag_w
         $error("TAG_W must lie in 1..8");
      end
      if (RID_W < 1 || RID_W > 16) begin : g_bad_rid_w
         $error("RID_W must lie in 1..16");
      end
   endgenerate

   hdr_ctl_t         ctl;
   logic             legal;
   hdr_t             hdr;
   logic [IDX_W-1:0] last_idx;
   logic             busy;
   logic             accept;
   logic             err_q;

   tlp_req_classify #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_classify (
      .addr_hi (req_addr[ADDR_W-1:32]),
      .write   (req_write),
      .io      (req_io),
      .len     (req_len),
      .rc_mode (rc_mode),
      .ctl     (ctl),
      .legal   (legal)
   );

   tlp_hdr_format #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W)) u_format (
      .ctl      (ctl),
      .addr     (req_addr),
      .len      (req_len),
      .tag      (req_tag),
      .rid      (req_rid),
      .hdr      (hdr),
      .last_idx (last_idx)
   );

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   tlp_hdr_sequencer u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && legal),
      .hdr_in    (hdr),
      .last_in   (last_idx),
      .busy      (busy),
      .out_ready (hdr_ready),
      .out_data  (hdr_data),
      .out_last  (hdr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= accept && !legal;
   end

   assign hdr_valid = busy;
   assign err_pulse = err_q;
endmodule

// File: rtl/tlp_hdr_builder_chk.sv
module tlp_hdr_builder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        hdr_valid,
   input logic        hdr_ready,
   input logic [31:0] hdr_data,
   input logic        hdr_last,
   input logic        err_pulse
);
   logic [1:0] beat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      beat_cnt <= 2'd0;
      else if (hdr_valid && hdr_ready) beat_cnt <= hdr_last ? 2'd0 : beat_cnt + 2'd1;
   end

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data) && $stable(hdr_last)); // R8
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> !req_ready); // R9
   AST_ERR_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(req_valid && req_ready)); // R6
   AST_ERR_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !hdr_valid); // R7
   AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_last |-> beat_cnt >= 2'd2); // R2
   AST_FOURTH_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && beat_cnt == 2'd3 |-> hdr_last); // R8
   AST_DW0_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && beat_cnt == 2'd0 |-> !hdr_data[31]); // R3
endmodule

bind tlp_hdr_builder tlp_hdr_builder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .hdr_valid (hdr_valid),
   .hdr_ready (hdr_ready),
   .hdr_data  (hdr_data),
   .hdr_last  (hdr_last),
   .err_pulse (err_pulse)
);

// File: tb/tb_tlp_hdr_builder.sv
module tb_tlp_hdr_builder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rc_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [35:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic [9:0]  req_len = '0;
   logic [7:0]  req_tag = '0;
   logic [15:0] req_rid = '0;
   logic        hdr_valid;
   logic        hdr_ready = 1'b0;
   logic [31:0] hdr_data;
   logic        hdr_last;
   logic        err_pulse;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlp_hdr_builder dut (
      .clk(clk), .rst_n(rst_n), .rc_mode(rc_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_io(req_io), .req_len(req_len),
      .req_tag(req_tag), .req_rid(req_rid),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
      .hdr_last(hdr_last), .err_pulse(err_pulse)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_req(input bit rc, input bit io, input bit wr, input logic [35:0] a,
                          input logic [9:0] ln, input logic [15:0] rid, input logic [7:0] tg,
                          input bit junk, input bit stall);
      logic [31:0] e [4];
      bit          above, legal, a64;
      int          n;
      above = |a[35:32];
      legal = !io || (rc && !above && ln == 10'd1);
      a64   = !io && above;
      e[0]  = {1'b0, wr, a64, (io ? 5'b00010 : 5'b00000), 14'd0, ln};
      e[1]  = {rid, tg, (ln == 10'd1 ? 4'h0 : 4'hF), 4'hF};
      if (a64) begin
         e[2] = {28'd0, a[35:32]};
         e[3] = {a[31:2], 2'b00};
         n    = 4;
      end else begin
         e[2] = {a[31:2], 2'b00};
         e[3] = '0;
         n    = 3;
      end
      chk(req_ready == 1'b1, "R9 idle ready", 32'(req_ready), 32'd1);
      rc_mode   = rc;
      req_io    = io;
      req_write = wr;
      req_addr  = a;
      req_len   = ln;
      req_rid   = rid;
      req_tag   = tg;
      req_valid = 1'b1;
      @(negedge clk);
      if (!legal) begin
         req_valid = 1'b0;
         chk(err_pulse == 1'b1, (io && !rc) ? "R6 err pulse" : "R7 err pulse", 32'(err_pulse), 32'd1);
         chk(hdr_valid == 1'b0, "R7 no header", 32'(hdr_valid), 32'd0);
         @(negedge clk);
         chk(err_pulse == 1'b0, "R6 pulse ends", 32'(err_pulse), 32'd0);
         chk(hdr_valid == 1'b0, "R6 still no header", 32'(hdr_valid), 32'd0);
         return;
      end
      req_valid = junk;
      if (junk) begin
         req_addr  = ~a;
         req_io    = 1'b0;
         req_len   = 10'd7;
      end
      chk(err_pulse == 1'b0, "R6 no err on legal", 32'(err_pulse), 32'd0);
      for (int i = 0; i < n; i++) begin
         if (stall && (i % 2 == 0)) begin
            hdr_ready = 1'b0;
            @(negedge clk);
            chk(hdr_valid && hdr_data == e[i], "R8 hold on stall", hdr_data, e[i]);
         end
         hdr_ready = 1'b1;
         chk(hdr_valid == 1'b1, "R8 valid", 32'(hdr_valid), 32'd1);
         chk(hdr_data == e[i], (i == 0) ? "R3 dword0" : (i == 1) ? "R4 dword1" : "R5 address dword",
             hdr_data, e[i]);
         chk(hdr_last == (i == n - 1), "R8 last flag", 32'(hdr_last), 32'(i == n - 1));
         chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 32'd0);
         if (i == n - 1) req_valid = 1'b0;
         @(negedge clk);
      end
      hdr_ready = 1'b0;
      chk(hdr_valid == 1'b0, "R2 dword count", 32'(hdr_valid), 32'd0);
      chk(req_ready == 1'b1, "R9 ready after last", 32'(req_ready), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(hdr_valid == 1'b0, "R1 reset valid", 32'(hdr_valid), 32'd0);
      chk(err_pulse == 1'b0, "R1 reset err", 32'(err_pulse), 32'd0);
      chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 boundary at 4 GiB
      run_req(1'b1, 1'b0, 1'b0, 36'h0_FFFF_FFFF, 10'd1, 16'hABCD, 8'h11, 1'b0, 1'b0);
      run_req(1'b1, 1'b0, 1'b1, 36'h1_0000_0000, 10'd4, 16'h1234, 8'h22, 1'b0, 1'b1);
      run_req(1'b1, 1'b1, 1'b1, 36'h0_0000_0CF8, 10'd1, 16'h0001, 8'h33, 1'b1, 1'b0);
      run_req(1'b1, 1'b1, 1'b0, 36'h0_0000_0CF8, 10'd0, 16'h0001, 8'h34, 1'b0, 1'b0); // R7 length

      for (int rc = 0; rc < 2; rc++)
         for (int io = 0; io < 2; io++)
            for (int wr = 0; wr < 2; wr++)
               for (int hi = 0; hi < 16; hi++)
                  for (int ls = 0; ls < 2; ls++) begin
                     logic [31:0] lo;
                     logic [9:0]  ln;
                     lo = 32'hDEAD_BEEF ^ (32'(hi) * 32'h0101_0107) ^ 32'(ls * 3);
                     ln = (ls == 0) ? 10'd1 : 10'(hi * 67 + 2);
                     run_req(rc[0], io[0], wr[0], {hi[3:0], lo}, ln, 16'(16'h1000 + hi * 5 + rc),
                             8'(hi * 13 + wr), (hi % 3) == 0, (hi % 2) == 1);
                  end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule